// File: doc/BRIEF.md
# Timer Status and Overcapture Flags

This block keeps the pending-event flags of a 16-bit up/down timer with four capture/compare channels. Each clock it looks at strobes from the counter (wrap up, wrap down, software reload, trigger reload) and from the channels (capture), and raises the matching sticky flags. An update flag records that the timer's shadow registers were refreshed. A capture flag per channel records a capture or compare event. An overcapture flag per channel records that a new capture arrived before software had serviced the previous one.

Software sees the flags as two byte-wide status registers on a simple register bus. It clears a flag by writing a 0 to its bit, and writing a 1 leaves the flag as it is. An interrupt request output combines every flag with its own enable bit. The counter, the capture data registers and the prescalers live in other blocks.

Top module: `tim_status_flags`

## Requirements
- R1: After reset both status bytes read 0x00 and `irq_o` is 0.
- R2: A wrap-up (`ovf_i`) or wrap-down (`unf_i`) strobe sets the update flag on the next clock edge when `upd_dis_i` is 0, and has no effect on the update flag when `upd_dis_i` is 1.
- R3: A software reload (`sw_upd_i`) or trigger reload (`trig_upd_i`) strobe sets the update flag only when both `upd_src_i` and `upd_dis_i` are 0.
- R4: A strobe on `cap_i[n]` sets channel n's capture flag on the next clock edge.
- R5: A strobe on `cap_i[n]` sets channel n's overcapture flag only when `ic_mode_i[n]` is 1 and that channel's capture flag was already 1 before the edge. Otherwise the overcapture flag is not set.
- R6: A write (`wr_en_i` high) clears each flag of the addressed byte whose data bit is 0. Flags whose data bit is 1 keep their value. A write to any address other than the two status addresses changes no flag.
- R7: Address 0 (first byte) holds the update flag in bit 0 and the channel 1 to 4 capture flags in bits 1 to 4. Address 1 (second byte) holds the channel 1 to 4 overcapture flags in bits 1 to 4. Bits 7:5 of both bytes and bit 0 of the second byte always read 0, and writes to them have no effect.
- R8: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up 1.
- R9: `irq_o` is 1 exactly when some flag is 1 and its enable bit in `irq_en_i` is 1. Enable bit 0 goes with the update flag, bits 1 to 4 with the capture flags of channels 1 to 4, and bits 5 to 8 with the overcapture flags of channels 1 to 4.
- R10: With `rd_en_i` high, `rdata_o` shows the addressed byte in the same cycle, with no clock edge needed. With `rd_en_i` low, or at an address that is not a status address, `rdata_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ovf_i | input | 1 | Counter wrapped while counting up |
| unf_i | input | 1 | Counter wrapped while counting down |
| sw_upd_i | input | 1 | Software reload of the counter |
| trig_upd_i | input | 1 | Trigger-driven reload of the counter |
| upd_dis_i | input | 1 | Update disable: blocks every update-flag source |
| upd_src_i | input | 1 | Update source select: 1 restricts the update flag to counter wraps |
| cap_i | input | 4 | Per-channel capture/compare event strobes |
| ic_mode_i | input | 4 | Per-channel input-capture mode select |
| irq_en_i | input | 9 | Per-flag interrupt enables |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read enable |
| addr_i | input | 2 | Register byte address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an overcapture. It needs two captures on the same channel in input-capture mode with no clearing write between them. A random write that clears the capture flag in between masks it, and so does a clear that arrives in the same cycle as the second capture. Directed sequences issue back-to-back captures with and without input-capture mode. The random phase uses dense capture strobes and only occasional writes, so repeated captures often land on flags that are still set. A cycle-level reference model in the bench predicts every flag, including clear and set in the same cycle.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int NUM_CH    = 4;
  localparam int DATA_W    = 8;
  localparam int NUM_FLAGS = 1 + 2 * NUM_CH;
  // flag vector layout: [0] update, [NUM_CH:1] capture, [2*NUM_CH:NUM_CH+1] overcapture
  localparam int UPD_IDX   = 0;
  localparam int CAP_LO    = 1;
  localparam int OVC_LO    = NUM_CH + 1;
endpackage

// File: rtl/tsf_update_gate.sv
module tsf_update_gate (
  input  logic ovf_i,
  input  logic unf_i,
  input  logic sw_upd_i,
  input  logic trig_upd_i,
  input  logic upd_dis_i,
  input  logic upd_src_i,
  output logic set_o
);
  logic wrap_evt;
  logic reload_evt;

  assign wrap_evt   = ovf_i | unf_i;
  assign reload_evt = sw_upd_i | trig_upd_i;
  // reloads only count when the source select allows every source
  assign set_o = ~upd_dis_i & (wrap_evt | (reload_evt & ~upd_src_i));
endmodule

// File: rtl/tsf_flag_cell.sv
module tsf_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;  // hardware set beats software clear
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/tsf_regmap.sv
module tsf_regmap #(
  parameter int NUM_CH    = tsf_pkg::NUM_CH,
  parameter int DATA_W    = tsf_pkg::DATA_W,
  parameter int ADDR_W    = 2,
  parameter int STAT0_ADR = 0,
  parameter int STAT1_ADR = 1,
  localparam int NF       = 1 + 2 * NUM_CH
) (
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NF-1:0]     flags_i,
  output logic [NF-1:0]     clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic sel0, sel1;
  logic [DATA_W-1:0] byte0, byte1;
  logic unused_wbits;

  assign sel0 = (addr_i == ADDR_W'(STAT0_ADR));
  assign sel1 = (addr_i == ADDR_W'(STAT1_ADR));
  assign unused_wbits = ^wdata_i[DATA_W-1:NUM_CH+1];

  assign clr_o[0] = wr_en_i & sel0 & ~wdata_i[0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign clr_o[1 + c]          = wr_en_i & sel0 & ~wdata_i[1 + c];
    assign clr_o[NUM_CH + 1 + c] = wr_en_i & sel1 & ~wdata_i[1 + c];
  end

  always_comb begin
    byte0 = '0;
    byte1 = '0;
    byte0[NUM_CH:0] = flags_i[NUM_CH:0];
    byte1[NUM_CH:1] = flags_i[2*NUM_CH:NUM_CH+1];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (sel0)      rdata_o = byte0;
      else if (sel1) rdata_o = byte1;
    end
  end
endmodule

// File: rtl/tim_status_flags.sv
module tim_status_flags #(
  parameter int NUM_CH    = tsf_pkg::NUM_CH,
  parameter int DATA_W    = tsf_pkg::DATA_W,
  parameter int ADDR_W    = 2,
  parameter int STAT0_ADR = 0,
  parameter int STAT1_ADR = 1,
  localparam int NF       = 1 + 2 * NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ovf_i,
  input  logic              unf_i,
  input  logic              sw_upd_i,
  input  logic              trig_upd_i,
  input  logic              upd_dis_i,
  input  logic              upd_src_i,
  input  logic [NUM_CH-1:0] cap_i,
  input  logic [NUM_CH-1:0] ic_mode_i,
  input  logic [NF-1:0]     irq_en_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NF-1:0] flags_q;
  logic [NF-1:0] set_vec;
  logic [NF-1:0] clr_vec;

  tsf_update_gate u_upd (
    .ovf_i      (ovf_i),
    .unf_i      (unf_i),
    .sw_upd_i   (sw_upd_i),
    .trig_upd_i (trig_upd_i),
    .upd_dis_i  (upd_dis_i),
    .upd_src_i  (upd_src_i),
    .set_o      (set_vec[0])
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign set_vec[1 + c]          = cap_i[c];
    // second capture while the first is unserviced
    assign set_vec[NUM_CH + 1 + c] = cap_i[c] & ic_mode_i[c] & flags_q[1 + c];
  end

  tsf_regmap #(
    .NUM_CH    (NUM_CH),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .STAT0_ADR (STAT0_ADR),
    .STAT1_ADR (STAT1_ADR)
  ) u_map (
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .flags_i (flags_q),
    .clr_o   (clr_vec),
    .rdata_o (rdata_o)
  );

  for (genvar f = 0; f < NF; f++) begin : g_flag
    tsf_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[f]),
      .clr_i  (clr_vec[f]),
      .q_o    (flags_q[f])
    );
  end

  assign irq_o = |(flags_q & irq_en_i);
endmodule

// File: rtl/tsf_checker.sv
module tsf_checker #(
  parameter int NUM_CH    = tsf_pkg::NUM_CH,
  parameter int DATA_W    = tsf_pkg::DATA_W,
  parameter int ADDR_W    = 2,
  parameter int STAT0_ADR = 0,
  parameter int STAT1_ADR = 1,
  localparam int NF       = 1 + 2 * NUM_CH
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ovf_i,
  input logic              unf_i,
  input logic              sw_upd_i,
  input logic              trig_upd_i,
  input logic              upd_dis_i,
  input logic              upd_src_i,
  input logic [NUM_CH-1:0] cap_i,
  input logic [NUM_CH-1:0] ic_mode_i,
  input logic [NF-1:0]     irq_en_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [NF-1:0]     flags_i
);
  logic upd_ok;
  logic any_upd_strobe;
  assign any_upd_strobe = ovf_i | unf_i | sw_upd_i | trig_upd_i;
  assign upd_ok = !upd_dis_i && ((ovf_i || unf_i) || (!upd_src_i && (sw_upd_i || trig_upd_i)));

  p_wrap_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ovf_i || unf_i) && !upd_dis_i) |=> flags_i[0]);

  p_upd_needs_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[0]) |-> $past(upd_ok));

  p_cap_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i != '0) |=> ((flags_i[NUM_CH:1] & $past(cap_i)) == $past(cap_i)));

  p_ovc_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_i[2*NUM_CH:NUM_CH+1] & ~$past(flags_i[2*NUM_CH:NUM_CH+1])
               & ~$past(cap_i & ic_mode_i & flags_i[NUM_CH:1])) == '0));

  p_clear_upd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(STAT0_ADR) && !wdata_i[0] && !any_upd_strobe) |=> !flags_i[0]);

  p_rsvd_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(STAT1_ADR)) |-> (rdata_o[0] == 1'b0 && rdata_o[DATA_W-1:NUM_CH+1] == '0));

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_ok && wr_en_i && addr_i == ADDR_W'(STAT0_ADR) && !wdata_i[0]) |=> flags_i[0]);

  p_irq_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_i & irq_en_i) == '0) |-> !irq_o);

  p_idle_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == '0));
endmodule

bind tim_status_flags tsf_checker #(
  .NUM_CH    (NUM_CH),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .STAT0_ADR (STAT0_ADR),
  .STAT1_ADR (STAT1_ADR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ovf_i      (ovf_i),
  .unf_i      (unf_i),
  .sw_upd_i   (sw_upd_i),
  .trig_upd_i (trig_upd_i),
  .upd_dis_i  (upd_dis_i),
  .upd_src_i  (upd_src_i),
  .cap_i      (cap_i),
  .ic_mode_i  (ic_mode_i),
  .irq_en_i   (irq_en_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .flags_i    (flags_q)
);

// File: tb/sim_tim_status_flags.sv
`timescale 1ns/1ps
module sim_tim_status_flags;
  localparam int NCH = 4;
  localparam int NF  = 1 + 2 * NCH;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           ovf_i = 0, unf_i = 0, sw_upd_i = 0, trig_upd_i = 0;
  logic           upd_dis_i = 0, upd_src_i = 0;
  logic [NCH-1:0] cap_i = '0, ic_mode_i = '0;
  logic [NF-1:0]  irq_en_i = '0;
  logic           wr_en_i = 0, rd_en_i = 0;
  logic [1:0]     addr_i = '0;
  logic [7:0]     wdata_i = '0;
  logic [7:0]     rdata_o;
  logic           irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [NF-1:0] exp_q = '0;

  always #2 clk_i = ~clk_i;

  tim_status_flags u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ovf_i(ovf_i), .unf_i(unf_i),
    .sw_upd_i(sw_upd_i), .trig_upd_i(trig_upd_i), .upd_dis_i(upd_dis_i),
    .upd_src_i(upd_src_i), .cap_i(cap_i), .ic_mode_i(ic_mode_i),
    .irq_en_i(irq_en_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [NF-1:0] model_next(input logic [NF-1:0] cur);
    logic [NF-1:0] nx = cur;
    if (wr_en_i && addr_i == 2'd0)
      for (int i = 0; i <= NCH; i++) if (!wdata_i[i]) nx[i] = 1'b0;
    if (wr_en_i && addr_i == 2'd1)
      for (int c = 0; c < NCH; c++) if (!wdata_i[c+1]) nx[NCH+1+c] = 1'b0;
    if (((ovf_i || unf_i) && !upd_dis_i) || ((sw_upd_i || trig_upd_i) && !upd_src_i && !upd_dis_i))
      nx[0] = 1'b1;
    for (int c = 0; c < NCH; c++)
      if (cap_i[c]) begin
        nx[1+c] = 1'b1;
        if (ic_mode_i[c] && cur[1+c]) nx[NCH+1+c] = 1'b1;
      end
    return nx;
  endfunction

  function automatic logic [7:0] byte0(input logic [NF-1:0] f);
    return {3'b000, f[NCH:1], f[0]};
  endfunction
  function automatic logic [7:0] byte1(input logic [NF-1:0] f);
    return {3'b000, f[2*NCH:NCH+1], 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    ovf_i = 0; unf_i = 0; sw_upd_i = 0; trig_upd_i = 0;
    cap_i = '0; wr_en_i = 0; wdata_i = '0;
  endtask

  // one clock with the current stimulus, model follows the edge
  task automatic cycle();
    logic [NF-1:0] nx;
    nx = model_next(exp_q);
    @(posedge clk_i);
    exp_q = nx;
    @(negedge clk_i);
  endtask

  task automatic check_all(input string tag);
    idle();
    rd_en_i = 1; addr_i = 2'd0; #0.2;
    chk(tag, rdata_o, byte0(exp_q));
    addr_i = 2'd1; #0.2;
    chk(tag, rdata_o, byte1(exp_q));
    chk("R9 irq", {7'b0, irq_o}, {7'b0, |(exp_q & irq_en_i)});
    addr_i = 2'd2; #0.2;
    chk("R10 unmapped", rdata_o, 8'h00);
    rd_en_i = 0; addr_i = 2'd0; #0.2;
    chk("R10 rd_en low", rdata_o, 8'h00);
  endtask

  task automatic apply(input string tag);
    cycle();
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    irq_en_i = '1;
    repeat (3) @(negedge clk_i);
    check_all("R1 reset");
    rst_ni = 1;
    @(negedge clk_i);
    check_all("R1 after release");

    // R2: wraps gated by update disable
    upd_dis_i = 1; ovf_i = 1; apply("R2 ovf blocked");
    upd_dis_i = 0; unf_i = 1; apply("R2 unf sets");
    wr_en_i = 1; addr_i = 2'd0; wdata_i = 8'hFE; apply("R6 clear update");

    // R3: reloads gated by both controls
    upd_src_i = 1; sw_upd_i = 1; apply("R3 sw blocked by src");
    upd_src_i = 0; upd_dis_i = 1; trig_upd_i = 1; apply("R3 trig blocked by dis");
    upd_dis_i = 0; trig_upd_i = 1; apply("R3 trig sets");
    upd_src_i = 1; ovf_i = 1; apply("R2 wrap with src set");
    upd_src_i = 0;

    // R4/R5: captures and overcaptures
    ic_mode_i = 4'hF; cap_i = 4'b0001; apply("R4 cap ch1");
    cap_i = 4'b0001; apply("R5 overcapture ch1");
    ic_mode_i = 4'b1101; cap_i = 4'b0010; apply("R4 cap ch2");
    cap_i = 4'b0010; apply("R5 no overcapture outside ic mode");
    cap_i = 4'b1000; apply("R4 cap ch4");
    wr_en_i = 1; addr_i = 2'd0; wdata_i = 8'hF7; apply("R6 clear cap ch3 only");
    cap_i = 4'b1100; apply("R5 ch4 overcapture, ch3 fresh");

    // R6/R7: write-one keeps, reserved bits, foreign address
    wr_en_i = 1; addr_i = 2'd0; wdata_i = 8'hFF; apply("R6 write ones keep");
    wr_en_i = 1; addr_i = 2'd2; wdata_i = 8'h00; apply("R6 foreign address");
    wr_en_i = 1; addr_i = 2'd1; wdata_i = 8'hE1; apply("R7 second byte clear, reserved set");
    wr_en_i = 1; addr_i = 2'd1; wdata_i = 8'hFF; apply("R7 reserved read zero");

    // R8: set and clear in same cycle
    wr_en_i = 1; addr_i = 2'd0; wdata_i = 8'h00; ovf_i = 1; cap_i = 4'b0100; apply("R8 set wins");

    // R9: enables select which flags raise irq
    irq_en_i = 9'h000; apply("R9 all masked");
    irq_en_i = 9'h020; apply("R9 only ch1 overcapture enabled");
    irq_en_i = 9'h001; apply("R9 update enabled");

    // random phase
    for (int n = 0; n < 600; n++) begin
      ovf_i      = ($urandom % 5) == 0;
      unf_i      = ($urandom % 7) == 0;
      sw_upd_i   = ($urandom % 6) == 0;
      trig_upd_i = ($urandom % 6) == 0;
      upd_dis_i  = ($urandom % 4) == 0;
      upd_src_i  = ($urandom % 2) == 0;
      cap_i      = NCH'($urandom);
      ic_mode_i  = NCH'($urandom | $urandom);
      irq_en_i   = NF'($urandom);
      wr_en_i    = ($urandom % 4) == 0;
      addr_i     = 2'($urandom);
      wdata_i    = 8'($urandom | $urandom);
      apply("R5 R6 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule